// File: doc/BRIEF.md
# Audio Serial Receiver

This block is a slave-side serial audio input port. It runs on the incoming bit clock. It samples the data line and the frame-sync line on every rising edge, and it finds frame boundaries from edges of the frame sync. From the serial stream it pulls one word per enabled channel. Each word leaves on a parallel valid/ready output, tagged with its channel number. The bit clock and the frame sync come from outside and are never generated here.

There are two framing modes. In the half-frame mode the frame sync is a square wave and at most two channels are in use. A per-channel phase bit picks whether that channel is taken while the frame sync is high or while it is low. The channel's bit location is then counted from the start of that half. In the time-division mode, locations are counted from the frame edge across the whole frame, and any number of the parameterised channels may be enabled. All settings are static inputs: the start-edge polarity, the frame length in bit clocks, the word width (16 to 32), and per channel an enable, a location and a phase bit.

The output is a single register. A word stays valid until it is accepted. The serial line cannot be stalled, so back-pressure has a limit. If a new word completes while the previous one has not been accepted, the new word replaces the old one and `overrun_o` pulses for one cycle. With `out_ready_i` held high, every word appears as a one-cycle valid pulse.

Top module: `aud_serial_rx`

## Requirements
- R1: With `start_rise_i`=0 a frame starts on a falling edge of the frame sync, and with 1 on a rising edge. Bit position 0 is the bit sampled on the first rising clock edge that sees the new frame-sync level.
- R2: In half-frame mode (`mode_5050_i`=1), a channel whose phase bit equals `start_rise_i` occupies the first half (positions 0 to N/2-1). Otherwise it occupies the second half (positions N/2 to N-1). Its location counts from the start of its own half.
- R3: In time-division mode (`mode_5050_i`=0), a channel's word occupies positions loc to loc+W-1, counted from the frame edge.
- R4: Words arrive MSB first. `word_len_i` W lies between 16 and 32. The word is presented right-justified in `out_data_o`, with the bits above W set to zero.
- R5: One clock after the last bit of a word is sampled, `out_valid_o` rises, carrying that word and the channel index in `out_chan_o`. `out_valid_o` stays high until a cycle in which `out_ready_i` is high. If two channels finish in the same cycle, the lower index wins.
- R6: A word that completes while an unaccepted word is pending replaces the pending word, and `overrun_o` is high for exactly that one cycle.
- R7: In half-frame mode with more than two channels enabled, `cfg_err_o` is 1 and no channel produces a word.
- R8: `cfg_err_o` is also 1 in two further cases. The first is W outside 16 to 32. The second is an enabled channel with loc+W larger than N/2 in half-frame mode, or larger than N in time-division mode. Only the offending channels are silenced, and loc+W equal to the limit is legal.
- R9: A start edge arriving while fewer than N bits of the current frame have passed restarts the bit count at 0. Any partly received word is dropped, and `sync_err_o` pulses one cycle later.
- R10: After reset, `out_valid_o`, `overrun_o` and `sync_err_o` are 0, and no word is captured before the first start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bit clock, data and frame sync sampled on rising edge |
| rst_n | input | 1 | asynchronous active-low reset |
| sdata_i | input | 1 | serial data |
| fsync_i | input | 1 | frame sync |
| mode_5050_i | input | 1 | 1 = half-frame mode, 0 = time-division mode |
| start_rise_i | input | 1 | 1 = frame starts on rising frame-sync edge |
| frame_len_i | input | CNT_W (10) | frame length N in bit clocks |
| word_len_i | input | 6 | word width W |
| ch_en_i | input | NCH (4) | per-channel enable |
| ch_loc_i | input | NCH*CNT_W (40) | per-channel bit location, channel c at bits [c*CNT_W +: CNT_W] |
| ch_hi_i | input | NCH (4) | per-channel phase bit (half-frame mode) |
| out_ready_i | input | 1 | consumer accepts the word |
| out_valid_o | output | 1 | word present |
| out_data_o | output | 32 | received word, right-justified |
| out_chan_o | output | 2 | channel index of the word |
| overrun_o | output | 1 | pending word was replaced |
| cfg_err_o | output | 1 | illegal setting |
| sync_err_o | output | 1 | early frame edge seen |

## Verification
The hardest case to reach is a frame edge that arrives while a word is only partly shifted in. The receiver must then both restart its count and throw that word away. The bench plays a frame and cuts it off in the middle of the second-half word. It starts a complete frame straight away, then checks that the cut channel yields exactly one word from the complete frame and that `sync_err_o` pulsed once. A second hard case is overrun. The bench holds ready low across a whole frame, so that the second channel's word lands on top of the first.

// File: rtl/asr_pkg.sv
package asr_pkg;
  localparam int WORD_MAX  = 32;
  localparam int WORD_MIN  = 16;
  localparam int WL_W      = $clog2(WORD_MAX + 1);
endpackage

// File: rtl/asr_framer.sv
module asr_framer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             start_rise,
  input  logic [CNT_W-1:0] frame_len,
  output logic [CNT_W-1:0] pos,
  output logic             active,
  output logic             sync_err
);
  logic             fs_q, primed_q, synced_q, err_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             edge_seen, early;

  assign edge_seen = primed_q & (start_rise ? (fsync & ~fs_q) : (~fsync & fs_q));
  assign cnt_inc   = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
  assign pos       = edge_seen ? '0 : cnt_inc;
  assign active    = synced_q | edge_seen;
  assign early     = edge_seen & synced_q &
                     (({1'b0, cnt_q} + (CNT_W+1)'(1)) < {1'b0, frame_len});
  assign sync_err  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q     <= 1'b0;
      primed_q <= 1'b0;
      synced_q <= 1'b0;
      cnt_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      fs_q     <= fsync;
      primed_q <= 1'b1;
      if (edge_seen) synced_q <= 1'b1;
      cnt_q    <= pos;
      err_q    <= early;
    end
  end

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_seen && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R9
  resync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (cnt_q == '0));
endmodule

// File: rtl/asr_cfg_check.sv
module asr_cfg_check
  import asr_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 10
) (
  input  logic                   mode_5050,
  input  logic                   start_rise,
  input  logic [CNT_W-1:0]       frame_len,
  input  logic [WL_W-1:0]        word_len,
  input  logic [NCH-1:0]         ch_en,
  input  logic [NCH*CNT_W-1:0]   ch_loc,
  input  logic [NCH-1:0]         ch_hi,
  output logic [NCH-1:0]         ch_ok,
  output logic [NCH*(CNT_W+1)-1:0] ch_eff,
  output logic                   cfg_err
);
  localparam int CW = $clog2(NCH + 1);
  localparam int E  = CNT_W + 2;

  logic [CW-1:0]    n_en;
  logic             too_many, wl_ok;
  logic [CNT_W-1:0] half;
  logic [E-1:0]     limit;
  logic [NCH-1:0]   bad;

  always_comb begin
    n_en = '0;
    for (int c = 0; c < NCH; c++) n_en = n_en + CW'(ch_en[c]);
  end

  assign too_many = mode_5050 & (n_en > CW'(2));
  assign wl_ok    = (word_len >= WL_W'(WORD_MIN)) & (word_len <= WL_W'(WORD_MAX));
  assign half     = frame_len >> 1;
  assign limit    = mode_5050 ? E'(half) : E'(frame_len);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CNT_W-1:0] loc;
    logic             fit, second;
    assign loc    = ch_loc[c*CNT_W +: CNT_W];
    assign second = mode_5050 & (ch_hi[c] != start_rise);
    assign fit    = (E'(loc) + E'(word_len)) <= limit;
    assign ch_eff[c*(CNT_W+1) +: (CNT_W+1)] =
      (CNT_W+1)'(loc) + (second ? (CNT_W+1)'(half) : '0);
    assign bad[c]   = ch_en[c] & ~(fit & wl_ok & ~too_many);
    assign ch_ok[c] = ch_en[c] & ~bad[c];
  end

  assign cfg_err = |bad;
endmodule

// File: rtl/asr_slot.sv
module asr_slot
  import asr_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int W     = WORD_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdata,
  input  logic             active,
  input  logic             ok,
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W:0]   eff,
  input  logic [WL_W-1:0]  word_len,
  output logic             done,
  output logic [W-1:0]     word
);
  localparam int E = CNT_W + 2;

  logic [W-1:0] sh_q, mask;
  logic [E-1:0] p_e, s_e, end_e;
  logic         in_slot;

  assign p_e     = E'(pos);
  assign s_e     = E'(eff);
  assign end_e   = s_e + E'(word_len);
  assign in_slot = active & ok & (p_e >= s_e) & (p_e < end_e);
  assign done    = in_slot & (p_e == end_e - E'(1));
  assign mask    = (word_len >= WL_W'(W)) ? '1 : ((W'(1) << word_len) - W'(1));
  assign word    = {sh_q[W-2:0], sdata} & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (in_slot) sh_q <= {sh_q[W-2:0], sdata};
  end
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import asr_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 10,
  parameter int W     = WORD_MAX,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sdata_i,
  input  logic                 fsync_i,
  input  logic                 mode_5050_i,
  input  logic                 start_rise_i,
  input  logic [CNT_W-1:0]     frame_len_i,
  input  logic [WL_W-1:0]      word_len_i,
  input  logic [NCH-1:0]       ch_en_i,
  input  logic [NCH*CNT_W-1:0] ch_loc_i,
  input  logic [NCH-1:0]       ch_hi_i,
  input  logic                 out_ready_i,
  output logic                 out_valid_o,
  output logic [W-1:0]         out_data_o,
  output logic [CH_W-1:0]      out_chan_o,
  output logic                 overrun_o,
  output logic                 cfg_err_o,
  output logic                 sync_err_o
);
  logic [CNT_W-1:0]         pos;
  logic                     active;
  logic [NCH-1:0]           ch_ok, done;
  logic [NCH*(CNT_W+1)-1:0] ch_eff;
  logic [W-1:0]             words [NCH];
  logic                     any_done;
  logic [CH_W-1:0]          pick;

  asr_framer #(.CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .fsync(fsync_i), .start_rise(start_rise_i),
    .frame_len(frame_len_i), .pos(pos), .active(active), .sync_err(sync_err_o)
  );

  asr_cfg_check #(.NCH(NCH), .CNT_W(CNT_W)) u_cfg (
    .mode_5050(mode_5050_i), .start_rise(start_rise_i), .frame_len(frame_len_i),
    .word_len(word_len_i), .ch_en(ch_en_i), .ch_loc(ch_loc_i), .ch_hi(ch_hi_i),
    .ch_ok(ch_ok), .ch_eff(ch_eff), .cfg_err(cfg_err_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    asr_slot #(.CNT_W(CNT_W), .W(W)) u_slot (
      .clk(clk), .rst_n(rst_n), .sdata(sdata_i), .active(active), .ok(ch_ok[c]),
      .pos(pos), .eff(ch_eff[c*(CNT_W+1) +: (CNT_W+1)]), .word_len(word_len_i),
      .done(done[c]), .word(words[c])
    );
  end

  always_comb begin
    any_done = 1'b0;
    pick     = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (done[c]) begin
        any_done = 1'b1;
        pick     = CH_W'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_chan_o  <= '0;
      overrun_o   <= 1'b0;
    end else if (any_done) begin
      out_valid_o <= 1'b1;
      out_data_o  <= words[pick];
      out_chan_o  <= pick;
      overrun_o   <= out_valid_o & ~out_ready_i;
    end else begin
      if (out_ready_i) out_valid_o <= 1'b0;
      overrun_o <= 1'b0;
    end
  end

  // R5
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> out_valid_o);

  // R6
  overrun_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> out_valid_o);

  // R7
  too_many_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_5050_i && $countones(ch_en_i) > 2) |-> !any_done);

  // R8
  chan_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_done) |-> ch_en_i[pick]);
endmodule

// File: tb/tb_aud_serial_rx.sv
module tb_aud_serial_rx;
  localparam int NCH = 4;
  localparam int CNT_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0, fsync = 1'b0;
  logic mode = 1'b1, rise = 1'b0;
  logic [9:0] N = 10'd64;
  logic [5:0] wl = 6'd24;
  logic [3:0] en = 4'b0011, hi = 4'b0010;
  logic [9:0] loc [4];
  logic [39:0] loc_flat;
  logic ready = 1'b1;
  logic out_valid, overrun, cfg_err, sync_err;
  logic [31:0] out_data;
  logic [1:0] out_chan;
  logic [31:0] vals [4];

  int n_chk = 0, n_fail = 0;
  int got_n [4];
  logic [31:0] got_v [4];
  int ovr_n = 0, serr_n = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  always_comb for (int c = 0; c < 4; c++) loc_flat[c*10 +: 10] = loc[c];

  aud_serial_rx dut (
    .clk(clk), .rst_n(rst_n), .sdata_i(sdata), .fsync_i(fsync),
    .mode_5050_i(mode), .start_rise_i(rise), .frame_len_i(N), .word_len_i(wl),
    .ch_en_i(en), .ch_loc_i(loc_flat), .ch_hi_i(hi), .out_ready_i(ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_chan_o(out_chan),
    .overrun_o(overrun), .cfg_err_o(cfg_err), .sync_err_o(sync_err)
  );

  // mode, rise, N, wl, loc0, loc1, ph0, ph1
  localparam logic [39:0] VEC [6] = '{
    {1'b1, 1'b0, 10'd64,  6'd24, 10'd0,  10'd0, 1'b0, 1'b1},
    {1'b1, 1'b1, 10'd64,  6'd16, 10'd3,  10'd5, 1'b0, 1'b1},
    {1'b1, 1'b0, 10'd64,  6'd32, 10'd0,  10'd0, 1'b1, 1'b0},
    {1'b0, 1'b1, 10'd128, 6'd20, 10'd40, 10'd7, 1'b0, 1'b0},
    {1'b0, 1'b0, 10'd64,  6'd32, 10'd32, 10'd0, 1'b0, 1'b0},
    {1'b1, 1'b1, 10'd48,  6'd16, 10'd8,  10'd8, 1'b1, 1'b0}
  };

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && ready) begin
        got_n[out_chan] = got_n[out_chan] + 1;
        got_v[out_chan] = out_data;
      end
      if (overrun)  ovr_n = ovr_n + 1;
      if (sync_err) serr_n = serr_n + 1;
    end
  end

  function automatic logic [31:0] msk(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  function automatic int beff(input int c);
    return int'(loc[c]) + ((mode && (hi[c] != rise)) ? int'(N) / 2 : 0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear();
    for (int c = 0; c < 4; c++) begin got_n[c] = 0; got_v[c] = '0; end
    ovr_n = 0;
    serr_n = 0;
  endtask

  task automatic do_reset(input logic idle_lvl);
    @(negedge clk);
    rst_n = 1'b0;
    fsync = idle_lvl;
    sdata = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    clear();
  endtask

  task automatic play_frame(input int lim);
    for (int p = 0; p < lim; p++) begin
      logic b;
      @(negedge clk);
      fsync = (p < int'(N) / 2) ? rise : !rise;
      b = 1'b0;
      for (int c = 0; c < 4; c++) begin
        int e;
        e = beff(c);
        if (en[c] && p >= e && p < e + int'(wl))
          b = b | vals[c][int'(wl) - 1 - (p - e)];
      end
      sdata = b;
    end
  endtask

  task automatic settle();
    @(negedge clk);
    sdata = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin loc[c] = '0; vals[c] = '0; end

    // R10: reset state, no capture before the first start edge
    mode = 1'b0; rise = 1'b1; N = 10'd64; wl = 6'd16; en = 4'b0001;
    do_reset(1'b1);
    @(negedge clk);
    chk("R10 valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R10 overrun after reset", {31'd0, overrun}, 32'd0);
    chk("R10 sync_err after reset", {31'd0, sync_err}, 32'd0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      sdata = 1'(i % 3);
    end
    settle();
    chk("R10 no word before start edge", got_n[0], 0);

    // Table of vectors: R1 R2 R3 R4 R5
    for (int i = 0; i < 6; i++) begin
      logic h0, h1;
      {mode, rise, N, wl, loc[0], loc[1], h0, h1} = VEC[i];
      hi = {2'b00, h1, h0};
      loc[2] = '0; loc[3] = '0;
      en = 4'b0011;
      vals[0] = 32'h9E37_79B9 ^ (32'h0101_0101 * i);
      vals[1] = 32'hC3A5_5A3C + 32'(i * 77);
      do_reset(!rise);
      play_frame(int'(N));
      settle();
      chk(mode ? "R1 R2 R5 ch0 count" : "R1 R3 R5 ch0 count", got_n[0], 1);
      chk(mode ? "R2 R4 ch0 word" : "R3 R4 ch0 word", got_v[0], vals[0] & msk(int'(wl)));
      chk(mode ? "R1 R2 R5 ch1 count" : "R1 R3 R5 ch1 count", got_n[1], 1);
      chk(mode ? "R2 R4 ch1 word" : "R3 R4 ch1 word", got_v[1], vals[1] & msk(int'(wl)));
      chk("R8 exact fit legal", {31'd0, cfg_err}, 32'd0);
    end

    // R9: early edge mid-word, partial discarded
    mode = 1'b1; rise = 1'b0; N = 10'd64; wl = 6'd24; en = 4'b0011;
    hi = 4'b0010; loc[0] = '0; loc[1] = '0;
    vals[0] = 32'h00AB_CDEF; vals[1] = 32'h0012_3456;
    do_reset(1'b1);
    play_frame(40);
    play_frame(64);
    settle();
    chk("R9 sync_err pulses", serr_n, 1);
    chk("R9 partial word dropped", got_n[1], 1);
    chk("R9 resynced word", got_v[1], 32'h0012_3456);
    chk("R9 first-half words", got_n[0], 2);

    // R6 and R5: back-pressure and overrun
    ready = 1'b0;
    do_reset(1'b1);
    play_frame(64);
    settle();
    repeat (4) @(negedge clk);
    chk("R5 valid held", {31'd0, out_valid}, 32'd1);
    chk("R6 overrun count", ovr_n, 1);
    chk("R6 replacing channel", {30'd0, out_chan}, 32'd1);
    chk("R6 replacing word", out_data, 32'h0012_3456);
    ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R5 valid drops once accepted", {31'd0, out_valid}, 32'd0);

    // R7: three channels in half-frame mode
    en = 4'b0111; loc[2] = '0;
    do_reset(1'b1);
    play_frame(64);
    settle();
    chk("R7 cfg_err", {31'd0, cfg_err}, 32'd1);
    chk("R7 no words", got_n[0] + got_n[1] + got_n[2], 0);

    // R8: one channel overruns its half
    en = 4'b0011; loc[1] = 10'd9;
    do_reset(1'b1);
    play_frame(64);
    settle();
    chk("R8 cfg_err on overhang", {31'd0, cfg_err}, 32'd1);
    chk("R8 good channel still works", got_v[0], 32'h00AB_CDEF);
    chk("R8 bad channel silent", got_n[1], 0);
    loc[1] = '0; wl = 6'd12;
    #1;
    chk("R8 R4 width too small", {31'd0, cfg_err}, 32'd1);

    // R3: four channels in time-division mode
    mode = 1'b0; rise = 1'b0; N = 10'd128; wl = 6'd16; en = 4'b1111; hi = '0;
    loc[0] = 10'd0; loc[1] = 10'd16; loc[2] = 10'd32; loc[3] = 10'd100;
    for (int c = 0; c < 4; c++) vals[c] = 32'h1000_0F0F * (c + 3);
    do_reset(1'b1);
    play_frame(128);
    settle();
    for (int c = 0; c < 4; c++) begin
      chk("R3 tdm count", got_n[c], 1);
      chk("R3 R4 tdm word", got_v[c], vals[c] & 32'h0000_FFFF);
    end

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule